// File: doc/BRIEF.md
# Triggered Circular Trace Buffer

This block stores one trace word per clock into an on-chip RAM while capture is on. The RAM is used as a ring: the write pointer wraps modulo the depth, and a sticky flag records that a wrap has happened. After a wrap the oldest word sits at the write pointer. Before a wrap the valid words run from address 0 up to one below the write pointer.

A trigger input arms a post-trigger countdown. Each word stored after the trigger word lowers the count by one. When the count reaches zero the acquisition is complete and capture stops by itself. The load value therefore decides how much of the ring is filled after the trigger. Two cycles after capture stops, a formatter-drained flag rises.

Software uses a plain address, write-data and write-enable port, plus a read strobe. Reading the data register returns the word at the read pointer and then moves that pointer on. The usual sequence is: load the countdown, clear the write pointer, set the enable bit, then poll the status and drain the ring.

Top module: `trace_ring_buffer`

## Requirements
- R1: After reset, reads return: address 0 the identity constant, address 1 the depth, address 2 the trace word width, address 3 (status) the value 8, and 0 for the control register (8), both pointers (5 read, 6 write) and the countdown (7). Every read returns its value on `reg_rdata` the cycle after the `reg_re` edge.
- R2: Capture begins on the clock edge after the control write that sets bit 0. While bit 0 is 1, every edge stores `trace_word` at the write pointer and increments the pointer modulo the depth.
- R3: Status bit 0 (full) sets on the store that moves the write pointer from depth-1 to 0. It stays set until capture is enabled again.
- R4: `trig_in` sampled while capture is on sets status bit 1 (triggered). When capture is off, `trig_in` has no effect.
- R5: After the trigger word is stored, the countdown (address 7) drops by one per stored word. Exactly N further words are stored for a load of N ≥ 1. On the last of them, status bit 2 (complete) sets and control bit 0 clears. With a load of 0, capture ends on the edge after the trigger word, and no further word is stored.
- R6: Status bit 3 (drained) clears when capture is enabled. It reads 1 from the third edge after the edge that stopped capture, and 0 before that.
- R7: A read of address 4 returns the RAM word at the read pointer. It then increments the read pointer modulo the depth. Address 5 is writable.
- R8: Writes to status, identity, depth and width have no effect. Enabling capture clears status bits 0 to 2.
- R9: A write to the write pointer takes priority over the increment from a store in the same cycle. The word captured in that cycle goes to the old pointer, and the next word goes to the written address.
- R10: Control bit 1 (demultiplexed port mode) is stored on every control write. It drives `demux_mode` and reads back at address 8.
- R11: Writing 0 to control stops capture after the store of that same edge. Full and triggered keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_word | input | TW | Trace word offered each cycle |
| trig_in | input | 1 | Trigger event |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| demux_mode | output | 1 | Port mode selected by control bit 1 |

## Verification
The two functions that collide are a software write of the write pointer and the pointer increment caused by a store in the same cycle. The bench places that write a known number of edges after the enable. It then reads back the RAM word at the old pointer and at the written address, and the final pointer. Since each trace word carries the index of the edge that stored it, both the placement and the count of words are judged exactly.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int REG_W = 32;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDENT   = 4'd0,
        SEL_DEPTH   = 4'd1,
        SEL_WIDTH   = 4'd2,
        SEL_STATUS  = 4'd3,
        SEL_DATA    = 4'd4,
        SEL_RDPTR   = 4'd5,
        SEL_WRPTR   = 4'd6,
        SEL_TRIGCNT = 4'd7,
        SEL_CTRL    = 4'd8
    } reg_sel_e;

    // packed: first member is the most significant bit, so full lands on bit 0
    typedef struct packed {
        logic empty;
        logic done;
        logic trig;
        logic full;
    } cap_flags_t;

    typedef struct packed {
        logic demux;
        logic en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] status_word(cap_flags_t f);
        return {{(REG_W-4){1'b0}}, f};
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
        return {{(REG_W-2){1'b0}}, c};
    endfunction

endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
    parameter int DEPTH = 64,
    parameter int TW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [TW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [TW-1:0] rdata
);

    logic [TW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
    import tcb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             ctrl_wr,
    input  ctrl_t            ctrl_wdata,
    input  logic             wptr_wr,
    input  logic [AW-1:0]    wptr_wdata,
    input  logic             cnt_wr,
    input  logic [REG_W-1:0] cnt_wdata,
    output logic             store,
    output logic [AW-1:0]    wptr,
    output logic [REG_W-1:0] cnt,
    output cap_flags_t       flags,
    output ctrl_t            ctrl
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    ctrl_t            ctrl_q;
    cap_flags_t       flags_q;
    logic [AW-1:0]    wptr_q;
    logic [REG_W-1:0] cnt_q;
    logic [1:0]       drain_q;

    logic cnt_is0, cnt_is1, armed, hit_zero, done_evt, start, halt, stop_evt;

    always_comb begin
        cnt_is0  = (cnt_q == '0);
        cnt_is1  = (cnt_q == REG_W'(1));
        armed    = ctrl_q.en & flags_q.trig;
        hit_zero = armed & cnt_is0;
        store    = ctrl_q.en & ~hit_zero;
        done_evt = hit_zero | (armed & cnt_is1);
        start    = ctrl_wr & ctrl_wdata.en;
        halt     = ctrl_wr & ~ctrl_wdata.en;
        stop_evt = ctrl_q.en & ~start & (done_evt | halt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '{empty: 1'b1, done: 1'b0, trig: 1'b0, full: 1'b0};
            wptr_q  <= '0;
            cnt_q   <= '0;
            drain_q <= '0;
        end else begin
            drain_q <= {drain_q[0], stop_evt};

            if (wptr_wr) begin
                wptr_q <= wptr_wdata;
            end else if (store) begin
                wptr_q <= wptr_q + 1'b1;
            end

            if (cnt_wr) begin
                cnt_q <= cnt_wdata;
            end else if (store && flags_q.trig && !cnt_is0) begin
                cnt_q <= cnt_q - REG_W'(1);
            end

            if (ctrl_wr) begin
                ctrl_q.demux <= ctrl_wdata.demux;
            end

            if (start) begin
                ctrl_q.en <= 1'b1;
                flags_q   <= '0;
                drain_q   <= '0;
            end else begin
                if (done_evt || halt) begin
                    ctrl_q.en <= 1'b0;
                end
                if (done_evt) begin
                    flags_q.done <= 1'b1;
                end
                if (store && (wptr_q == LAST) && !wptr_wr) begin
                    flags_q.full <= 1'b1;
                end
                if (ctrl_q.en && trig_in) begin
                    flags_q.trig <= 1'b1;
                end
                if (drain_q[1]) begin
                    flags_q.empty <= 1'b1;
                end
            end
        end
    end

    assign wptr  = wptr_q;
    assign cnt   = cnt_q;
    assign flags = flags_q;
    assign ctrl  = ctrl_q;

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
        flags_q.done |-> !ctrl_q.en);                                       // R5
    AST_DRAINED_IDLE: assert property (@(posedge clk) disable iff (rst)
        flags_q.empty |-> !ctrl_q.en);                                      // R6
    AST_WRAP_FULL: assert property (@(posedge clk) disable iff (rst)
        store && wptr_q == LAST && !wptr_wr && !start |=> flags_q.full);    // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        store && flags_q.trig && !cnt_is0 && !cnt_wr |=> cnt_q == $past(cnt_q) - REG_W'(1)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en && !wptr_wr |=> $stable(wptr_q));                        // R2
    AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags_q.trig && !start |=> flags_q.trig);                           // R4

endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
    import tcb_pkg::*;
#(
    parameter int          DEPTH = 64,
    parameter int          TW    = 32,
    parameter logic [31:0] IDENT = 32'h7B0C_0001,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             we,
    input  logic             re,
    input  cap_flags_t       flags,
    input  ctrl_t            ctrl,
    input  logic [AW-1:0]    wptr,
    input  logic [REG_W-1:0] cnt,
    input  logic [TW-1:0]    ram_rdata,
    output logic [AW-1:0]    rptr,
    output logic             ctrl_wr,
    output logic             wptr_wr,
    output logic             cnt_wr,
    output logic [REG_W-1:0] rdata
);

    reg_sel_e         sel;
    logic [AW-1:0]    rptr_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] mux;
    logic             data_rd;

    always_comb begin
        sel     = reg_sel_e'(addr);
        ctrl_wr = we && (sel == SEL_CTRL);
        wptr_wr = we && (sel == SEL_WRPTR);
        cnt_wr  = we && (sel == SEL_TRIGCNT);
        data_rd = re && (sel == SEL_DATA);
        case (sel)
            SEL_IDENT:   mux = IDENT;
            SEL_DEPTH:   mux = REG_W'(DEPTH);
            SEL_WIDTH:   mux = REG_W'(TW);
            SEL_STATUS:  mux = status_word(flags);
            SEL_DATA:    mux = REG_W'(ram_rdata);
            SEL_RDPTR:   mux = REG_W'(rptr_q);
            SEL_WRPTR:   mux = REG_W'(wptr);
            SEL_TRIGCNT: mux = cnt;
            SEL_CTRL:    mux = ctrl_word(ctrl);
            default:     mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (we && sel == SEL_RDPTR) begin
                rptr_q <= wdata[AW-1:0];
            end else if (data_rd) begin
                rptr_q <= rptr_q + 1'b1;
            end
            if (re) begin
                rdata_q <= mux;
            end
        end
    end

    assign rptr  = rptr_q;
    assign rdata = rdata_q;

    AST_RPTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        data_rd && !we |=> rptr_q == AW'($past(rptr_q) + 1'b1));           // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata_q));                                          // R1

endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer
    import tcb_pkg::*;
#(
    parameter int          DEPTH = 64,
    parameter int          TW    = 32,
    parameter logic [31:0] IDENT = 32'h7B0C_0001,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] trace_word,
    input  logic          trig_in,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          reg_we,
    input  logic          reg_re,
    output logic [31:0]   reg_rdata,
    output logic          demux_mode
);

    logic             store;
    logic [AW-1:0]    wptr, rptr;
    logic [REG_W-1:0] cnt;
    cap_flags_t       flags;
    ctrl_t            ctrl;
    logic             ctrl_wr, wptr_wr, cnt_wr;
    logic [TW-1:0]    ram_rdata;

    tcb_capture #(.DEPTH(DEPTH)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .trig_in    (trig_in),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_t'(reg_wdata[1:0])),
        .wptr_wr    (wptr_wr),
        .wptr_wdata (reg_wdata[AW-1:0]),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (reg_wdata),
        .store      (store),
        .wptr       (wptr),
        .cnt        (cnt),
        .flags      (flags),
        .ctrl       (ctrl)
    );

    tcb_ram #(.DEPTH(DEPTH), .TW(TW)) u_ram (
        .clk   (clk),
        .we    (store),
        .waddr (wptr),
        .wdata (trace_word),
        .raddr (rptr),
        .rdata (ram_rdata)
    );

    tcb_regs #(.DEPTH(DEPTH), .TW(TW), .IDENT(IDENT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .re        (reg_re),
        .flags     (flags),
        .ctrl      (ctrl),
        .wptr      (wptr),
        .cnt       (cnt),
        .ram_rdata (ram_rdata),
        .rptr      (rptr),
        .ctrl_wr   (ctrl_wr),
        .wptr_wr   (wptr_wr),
        .cnt_wr    (cnt_wr),
        .rdata     (reg_rdata)
    );

    assign demux_mode = ctrl.demux;

endmodule

// File: tb/tb_trace_ring_buffer.sv
`timescale 1ns/1ps
module tb_trace_ring_buffer;

    localparam int          D  = 16;
    localparam logic [31:0] ID = 32'h7B0C_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] trace_word = '0;
    logic        trig_in = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        demux_mode;

    trace_ring_buffer #(.DEPTH(D), .TW(32), .IDENT(ID)) dut (
        .clk(clk), .rst(rst), .trace_word(trace_word), .trig_in(trig_in),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata), .demux_mode(demux_mode)
    );

    always #4 clk = ~clk;

    int ntest = 0;
    int nfail = 0;
    int edge_n = 0;
    bit ended = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always @(posedge clk) edge_n <= edge_n + 1;
    // word stored on edge k carries the value k
    always @(negedge clk) trace_word <= 32'(edge_n + 1);
    always @(posedge clk) rd_seen <= reg_re;

    // monitor: compare each registered read against the scoreboard
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            ntest++;
            if (reg_rdata !== e) begin
                nfail++;
                $display("FAIL %s: got %08h expected %08h", t, reg_rdata, e);
            end
        end
    end

    function automatic int nxt();
        return edge_n + 1;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        reg_addr = a; reg_re = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
        ntest++;
        if (got !== e) begin
            nfail++;
            $display("FAIL %s: got %08h expected %08h", t, got, e);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int p, q, t, w, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(0, ID, "R1 identity");
        rd(1, D, "R1 depth");
        rd(2, 32, "R1 width");
        rd(3, 8, "R1 status");
        rd(8, 0, "R1 control");
        rd(5, 0, "R1 read pointer");
        rd(6, 0, "R1 write pointer");
        rd(7, 0, "R1 countdown");

        // R2 basic capture, R6 drain timing, R11 stop
        wr(7, 100);
        p = nxt(); wr(8, 1);
        idle(2);
        rd(3, 0, "R6 drained clears on enable");
        q = nxt(); wr(8, 0);
        n = q - p;
        idle(1);
        rd(3, 0, "R6 drained low two edges after stop");
        rd(3, 8, "R6 drained high third edge after stop");
        rd(8, 0, "R11 control cleared");
        rd(6, n, "R2 write pointer count");
        wr(5, 0);
        for (int i = 0; i < n; i++) rd(4, p + 1 + i, "R2 stored word");
        rd(5, n, "R7 read pointer advanced");

        // R3 wrap and oldest-first readout
        wr(6, 0);
        p = nxt(); wr(8, 1);
        idle(20);
        q = nxt(); wr(8, 0);
        n = q - p;
        idle(3);
        rd(3, 9, "R3 full set, R11 kept after stop");
        rd(6, n % D, "R3 write pointer wrapped");
        wr(5, n % D);
        for (int i = 0; i < D; i++) rd(4, p + 1 + (n - D + i), "R7 oldest first");
        rd(5, n % D, "R7 read pointer wrapped");

        // R4 trigger ignored while idle, R8 ignored writes
        pulse_trig();
        wr(3, 32'hF);
        rd(3, 9, "R4 R8 status unchanged");
        wr(0, 32'h0);
        rd(0, ID, "R8 identity unchanged");
        wr(1, 32'h3);
        rd(1, D, "R8 depth unchanged");

        // R5 countdown of 5
        wr(7, 5);
        wr(6, 0);
        p = nxt(); wr(8, 1);
        rd(3, 0, "R8 enable clears flags");
        t = nxt(); pulse_trig();
        idle(12);
        n = t - p + 5;
        rd(3, 14, "R4 R5 triggered and complete");
        rd(8, 0, "R5 enable cleared");
        rd(7, 0, "R5 countdown at zero");
        rd(6, n, "R5 words after trigger");
        wr(5, n - 1);
        rd(4, t + 5, "R5 last word");
        wr(5, t - p - 1);
        rd(4, t, "R4 trigger word");

        // R5 countdown of 0
        wr(7, 0);
        wr(6, 0);
        p = nxt(); wr(8, 1);
        idle(2);
        t = nxt(); pulse_trig();
        idle(6);
        n = t - p;
        rd(6, n, "R5 zero load stops after trigger word");
        rd(3, 14, "R5 zero load status");
        wr(5, n - 1);
        rd(4, t, "R5 zero load last word");

        // R9 pointer write against store
        wr(7, 100);
        wr(6, 0);
        p = nxt(); wr(8, 1);
        idle(1);
        w = nxt(); wr(6, 10);
        idle(1);
        q = nxt(); wr(8, 0);
        idle(3);
        rd(6, 10 + (q - w), "R9 pointer after collision");
        wr(5, 1);
        rd(4, w, "R9 word at old pointer");
        wr(5, 10);
        rd(4, w + 1, "R9 word at written pointer");

        // R10 port mode bit
        wr(8, 3);
        chk(32'(demux_mode), 1, "R10 demux output set");
        rd(8, 3, "R10 control readback");
        wr(8, 0);
        chk(32'(demux_mode), 0, "R10 demux output cleared");

        idle(4);
        chk(32'(exp_q.size()), 0, "R1 scoreboard drained");
        finish_run();
    end

endmodule